// File: doc/BRIEF.md
# CAN Receive Mailbox Bank

This block sits behind a CAN protocol engine. It takes each fully received frame and writes it into one slot of a bank of receive mailboxes. A frame carries an identifier, the extended-format and remote flags, a length and eight data bytes. Software configures each mailbox beforehand through a simple register port. The configuration covers enable, direction, identifier word, local acceptance mask and overwrite protection. Afterwards software reads stored frames back through the same port.

The bank picks the destination by mailbox number. The highest-numbered eligible mailbox wins, and a mailbox is eligible only if its masked identifier comparison passes. If a protected mailbox still holds an unread frame, it is skipped in favour of the next lower eligible one. Two per-mailbox vectors are kept. One marks frames waiting to be read; software clears a bit by writing 1 to it. The other marks frames that overwrote unread contents. A frame that finds no home is discarded with a one-cycle drop pulse.

Top module: `can_rx_mbox_bank`

## Requirements
- R1: Of all mailboxes that qualify for a frame, the one with the highest index receives it.
- R2: A mailbox whose enable bit is 0, or whose direction bit is 0 (transmit), never receives a frame. Setting its enable bit makes it eligible.
- R3: With the identifier word's bit 30 (mask enable) at 0, a mailbox matches only when the extended flag (bit 31) and the packed identifier bits 28:0 equal those of the frame.
- R4: With bit 30 at 1, a local mask bit of 1 makes the matching identifier bit a don't-care. Mask bit 31 makes the extended flag a don't-care, so an all-ones mask accepts every frame.
- R5: A stored frame rewrites the identifier word as follows. Bit 31 is the extended flag. Bits 30 and 29 keep their configured values. A standard 11-bit identifier is placed in bits 28:18 with zeros below, and an extended 29-bit identifier fills bits 28:0. The control word holds the length in bits 3:0 and the remote flag in bit 4.
- R6: Input data bits 63:56 hold byte 0. Bytes 0 to 3 are stored in the data-low word with byte 0 in bits 31:24, and bytes 4 to 7 in the data-high word.
- R7: Storing a frame sets that mailbox's pending bit on the clock edge that captures it. Writing 1 to a pending bit clears it. A frame store in the same cycle as a clear of the same bit leaves it set.
- R8: A mailbox whose protect bit is 1 and whose pending bit is 1 is skipped, and the next lower qualifying mailbox receives the frame.
- R9: A frame stored into a mailbox that is already pending sets that mailbox's lost bit. Writing 1 to a lost bit clears it.
- R10: When no mailbox qualifies, the frame is discarded. The drop output is 1 for exactly the one cycle after the frame, and no mailbox content or vector changes.
- R11: After reset the pending, lost, enable, direction and protect vectors and the drop output are 0.
- R12: Register map: address bit 8 = 0 selects mailbox word `addr[7:3]`, with `addr[2:0]` as 0 identifier, 1 control, 2 data low, 3 data high, 4 mask. Address bit 8 = 1 selects, by `addr[2:0]`, the vectors 0 enable, 1 direction, 2 pending, 3 lost, 4 protect. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe: a received frame is presented |
| frm_ext | input | 1 | Frame uses a 29-bit identifier |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_id | input | 29 | Identifier; standard frames use bits 10:0 |
| frm_len | input | 4 | Length code |
| frm_data | input | 64 | Data, byte 0 in bits 63:56 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 9 | Register read address |
| rd_data | output | 32 | Register read data |
| rx_pend | output | 32 | Pending vector |
| rx_lost | output | 32 | Lost vector |
| frm_drop | output | 1 | One-cycle pulse for a discarded frame |

## Verification
The hardest state to reach from the ports is full exhaustion under overwrite protection. Every matching mailbox must be pending and protected at once, so that a frame is dropped rather than redirected. The stimulus gets there by protecting the two catch-all mailboxes, filling both with frames, and then sending a third. It checks that the drop pulse appears and that the earlier contents stay intact. A second awkward case is the race between a software clear and a hardware set of the same pending bit. It is produced by driving the write and the frame on the same clock edge.

// File: rtl/can_rx_mbox_bank.sv
module can_rx_mbox_bank #(
  parameter int NUM_MBOX = 32,
  parameter int AW       = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frm_valid,
  input  logic                frm_ext,
  input  logic                frm_rtr,
  input  logic [28:0]         frm_id,
  input  logic [3:0]          frm_len,
  input  logic [63:0]         frm_data,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [31:0]         rd_data,
  output logic [NUM_MBOX-1:0] rx_pend,
  output logic [NUM_MBOX-1:0] rx_lost,
  output logic                frm_drop
);
  localparam int IDXW = $clog2(NUM_MBOX);

  logic [31:0] id_q  [NUM_MBOX];
  logic [31:0] msk_q [NUM_MBOX];
  logic [31:0] dlo_q [NUM_MBOX];
  logic [31:0] dhi_q [NUM_MBOX];
  logic [4:0]  ctl_q [NUM_MBOX];
  logic [NUM_MBOX-1:0] en_q, dir_q, pend_q, lost_q, prot_q, cand;
  logic [IDXW-1:0] sel_idx;
  logic sel_any, drop_q;

  wire [28:0] in_id = frm_ext ? frm_id : {frm_id[10:0], 18'b0};

  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_match
    wire        ame    = id_q[i][30];
    wire [28:0] idcare = ame ? ~msk_q[i][28:0] : '1;
    wire        idecar = ~(ame & msk_q[i][31]);
    wire        id_ok  = ((id_q[i][28:0] ^ in_id) & idcare) == '0;
    wire        ide_ok = ~idecar | (id_q[i][31] == frm_ext);
    assign cand[i] = en_q[i] & dir_q[i] & id_ok & ide_ok & ~(prot_q[i] & pend_q[i]);
  end

  always_comb begin
    sel_idx = '0;
    sel_any = 1'b0;
    for (int i = 0; i < NUM_MBOX; i++)
      if (cand[i]) begin
        sel_idx = IDXW'(i);
        sel_any = 1'b1;
      end
  end

  wire                store     = frm_valid & sel_any;
  wire [NUM_MBOX-1:0] store_vec = store ? (NUM_MBOX'(1) << sel_idx) : '0;
  wire                w_glb     = wr_en & wr_addr[AW-1];
  wire                w_mb      = wr_en & ~wr_addr[AW-1];
  wire [IDXW-1:0]     widx      = wr_addr[IDXW+2:3];
  wire [IDXW-1:0]     ridx      = rd_addr[IDXW+2:3];
  wire [NUM_MBOX-1:0] wvec      = wr_data[NUM_MBOX-1:0];
  wire [NUM_MBOX-1:0] pclr      = (w_glb && wr_addr[2:0] == 3'd2) ? wvec : '0;
  wire [NUM_MBOX-1:0] lclr      = (w_glb && wr_addr[2:0] == 3'd3) ? wvec : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      dir_q  <= '0;
      pend_q <= '0;
      lost_q <= '0;
      prot_q <= '0;
      drop_q <= 1'b0;
      for (int i = 0; i < NUM_MBOX; i++) begin
        id_q[i]  <= '0;
        msk_q[i] <= '0;
        dlo_q[i] <= '0;
        dhi_q[i] <= '0;
        ctl_q[i] <= '0;
      end
    end else begin
      drop_q <= frm_valid & ~sel_any;
      pend_q <= (pend_q & ~pclr) | store_vec;
      lost_q <= (lost_q & ~lclr) | (store_vec & pend_q);
      if (w_glb) begin
        case (wr_addr[2:0])
          3'd0: en_q   <= wvec;
          3'd1: dir_q  <= wvec;
          3'd4: prot_q <= wvec;
          default: ;
        endcase
      end
      if (w_mb) begin
        case (wr_addr[2:0])
          3'd0: id_q[widx]  <= wr_data;
          3'd1: ctl_q[widx] <= wr_data[4:0];
          3'd2: dlo_q[widx] <= wr_data;
          3'd3: dhi_q[widx] <= wr_data;
          3'd4: msk_q[widx] <= wr_data;
          default: ;
        endcase
      end
      if (store) begin
        id_q[sel_idx]  <= {frm_ext, id_q[sel_idx][30:29], in_id};
        ctl_q[sel_idx] <= {frm_rtr, frm_len};
        dlo_q[sel_idx] <= frm_data[63:32];
        dhi_q[sel_idx] <= frm_data[31:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr[AW-1]) begin
      case (rd_addr[2:0])
        3'd0: rd_data = 32'(en_q);
        3'd1: rd_data = 32'(dir_q);
        3'd2: rd_data = 32'(pend_q);
        3'd3: rd_data = 32'(lost_q);
        3'd4: rd_data = 32'(prot_q);
        default: ;
      endcase
    end else begin
      case (rd_addr[2:0])
        3'd0: rd_data = id_q[ridx];
        3'd1: rd_data = 32'(ctl_q[ridx]);
        3'd2: rd_data = dlo_q[ridx];
        3'd3: rd_data = dhi_q[ridx];
        3'd4: rd_data = msk_q[ridx];
        default: ;
      endcase
    end
  end

  assign rx_pend  = pend_q;
  assign rx_lost  = lost_q;
  assign frm_drop = drop_q;
endmodule

module can_rx_mbox_bank_chk #(
  parameter int NUM_MBOX = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frm_valid,
  input logic [NUM_MBOX-1:0] rx_pend,
  input logic [NUM_MBOX-1:0] rx_lost,
  input logic                frm_drop
);
  // R10
  drop_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_drop |-> $past(frm_valid));
  // R10
  drop_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_drop |-> ((rx_pend & ~$past(rx_pend)) == '0));
  // R7
  pend_rise_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_pend & ~$past(rx_pend)) != '0) |-> $past(frm_valid));
  // R7
  pend_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rx_pend & ~$past(rx_pend)) <= 1);
  // R9
  lost_was_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_lost & ~$past(rx_lost) & ~$past(rx_pend)) == '0));
endmodule

bind can_rx_mbox_bank can_rx_mbox_bank_chk #(.NUM_MBOX(NUM_MBOX)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid),
  .rx_pend(rx_pend), .rx_lost(rx_lost), .frm_drop(frm_drop)
);

// File: tb/can_rx_mbox_bank_tb.sv
module can_rx_mbox_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {ext, rtr, id[28:0], len[3:0], data[63:0], expected mailbox (63 = none)}
  localparam logic [104:0] VECS [NV] = '{
    {1'b0, 1'b0, 29'h123,      4'd8,  64'h0011223344556677, 6'd31},
    {1'b0, 1'b1, 29'h124,      4'd0,  64'hA5A5A5A5_5A5A5A5A, 6'd27},
    {1'b1, 1'b0, 29'h1ABCDE55, 4'd5,  64'hDEADBEEF_01020304, 6'd30},
    {1'b1, 1'b0, 29'h1ABCDF00, 4'd3,  64'h11111111_22222222, 6'd27},
    {1'b1, 1'b1, 29'h00000123, 4'd1,  64'hFEDCBA98_76543210, 6'd27},
    {1'b0, 1'b0, 29'h7FF,      4'd15, 64'h80000000_00000001, 6'd27}
  };

  logic clk = 0, rst_n = 0;
  logic frm_valid = 0, frm_ext = 0, frm_rtr = 0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_len = '0;
  logic [63:0] frm_data = '0;
  logic wr_en = 0;
  logic [8:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data, rv;
  logic [31:0] rx_pend, rx_lost;
  logic frm_drop;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rx_mbox_bank u_dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ext(frm_ext),
    .frm_rtr(frm_rtr), .frm_id(frm_id), .frm_len(frm_len), .frm_data(frm_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .rx_pend(rx_pend), .rx_lost(rx_lost), .frm_drop(frm_drop)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] mba(input int idx, input int w);
    return {1'b0, 5'(idx), 3'(w)};
  endfunction

  function automatic logic [31:0] exp_id(input logic ext, input logic [28:0] id, input logic ame);
    return ext ? {1'b1, ame, 1'b0, id} : {1'b0, ame, 1'b0, id[10:0], 18'b0};
  endfunction

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic send(input logic ext, input logic rtr, input logic [28:0] id,
                      input logic [3:0] len, input logic [63:0] d);
    @(negedge clk);
    frm_valid = 1; frm_ext = ext; frm_rtr = rtr; frm_id = id; frm_len = len; frm_data = d;
    @(negedge clk);
    frm_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 pend", rx_pend, 32'h0);
    check("R11 lost", rx_lost, 32'h0);
    check("R11 drop", 32'(frm_drop), 32'h0);
    rd(9'h100, rv); check("R11 enable", rv, 32'h0);
    rst_n = 1;

    wr(mba(31, 0), {3'b000, 11'h123, 18'h0});
    wr(mba(30, 0), {1'b1, 1'b1, 1'b0, 29'h1ABCDE00});
    wr(mba(30, 4), 32'h000000FF);
    for (int m = 26; m <= 29; m++) begin
      wr(mba(m, 0), 32'h40000000);
      wr(mba(m, 4), 32'hFFFFFFFF);
    end
    wr(9'h100, 32'hEC000000);
    wr(9'h101, 32'hDC000000);
    wr(9'h104, 32'h04000000);
    rd(9'h100, rv); check("R12 enable readback", rv, 32'hEC000000);

    for (int v = 0; v < NV; v++) begin
      logic [104:0] e;
      int m;
      e = VECS[v];
      m = int'(e[5:0]);
      send(e[104], e[103], e[102:74], e[73:70], e[69:6]);
      check("R1 R2 R3 R4 selected mailbox", rx_pend, 32'h1 << m);
      rd(mba(m, 0), rv); check("R5 identifier word", rv, exp_id(e[104], e[102:74], m != 31));
      rd(mba(m, 1), rv); check("R5 control word", rv, {27'b0, e[103], e[73:70]});
      rd(mba(m, 2), rv); check("R6 data low", rv, e[69:38]);
      rd(mba(m, 3), rv); check("R6 data high", rv, e[37:6]);
      wr(9'h102, 32'hFFFFFFFF);
      check("R7 pending cleared by write", rx_pend, 32'h0);
    end

    send(1'b0, 1'b0, 29'h300, 4'd8, 64'hAAAA0000_00000001);
    check("R7 pending set", rx_pend, 32'h08000000);
    send(1'b0, 1'b0, 29'h301, 4'd8, 64'hBBBB0000_00000002);
    check("R9 lost on overwrite", rx_lost, 32'h08000000);
    rd(mba(27, 2), rv); check("R9 overwritten data", rv, 32'hBBBB0000);

    wr(9'h104, 32'h0C000000);
    send(1'b0, 1'b0, 29'h302, 4'd8, 64'hCCCC0000_00000003);
    check("R8 redirected to lower", rx_pend, 32'h0C000000);
    check("R8 no new loss", rx_lost, 32'h08000000);
    rd(mba(27, 2), rv); check("R8 protected kept", rv, 32'hBBBB0000);

    send(1'b0, 1'b0, 29'h303, 4'd8, 64'hDDDD0000_00000004);
    check("R10 drop pulse", 32'(frm_drop), 32'h1);
    check("R10 pend unchanged", rx_pend, 32'h0C000000);
    check("R10 lost unchanged", rx_lost, 32'h08000000);
    rd(mba(26, 2), rv); check("R10 content unchanged", rv, 32'hCCCC0000);
    @(negedge clk);
    check("R10 pulse one cycle", 32'(frm_drop), 32'h0);

    wr(9'h103, 32'h08000000);
    check("R9 lost cleared", rx_lost, 32'h0);
    wr(9'h102, 32'h04000000);
    check("R7 single clear", rx_pend, 32'h08000000);

    wr(9'h104, 32'h04000000);
    @(negedge clk);
    wr_en = 1; wr_addr = 9'h102; wr_data = 32'h08000000;
    frm_valid = 1; frm_ext = 0; frm_rtr = 0; frm_id = 29'h304; frm_len = 4'd2;
    frm_data = 64'hEEEE0000_00000005;
    @(negedge clk);
    wr_en = 0; frm_valid = 0;
    check("R7 set wins over clear", rx_pend, 32'h08000000);
    check("R9 lost on race", rx_lost, 32'h08000000);

    wr(9'h102, 32'hFFFFFFFF);
    wr(9'h100, 32'hFC000000);
    send(1'b0, 1'b0, 29'h305, 4'd4, 64'h12345678_9ABCDEF0);
    check("R2 enabled mailbox eligible", rx_pend, 32'h10000000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule